// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a register-mapped watchdog for a platform controller. Software loads a tick count and then keeps writing the reload offset to hold off expiry. Ticks are coarse, nominally 0.6 s each. An external prescaler supplies them as one-cycle enable pulses on `tick_en`. When the count runs out the first time, the block raises a system-management interrupt. If SMI routing is off, it raises a non-maskable interrupt instead. It then reloads and keeps counting.

If the count runs out again before software reloads it, that second expiry is treated as a hung system. The block then pulses a reset request and stops, unless the `no_reboot` strap holds the reboot off. In that case it raises the interrupt again.

The registers sit in a 32-byte window with byte addresses. There is one write strobe and one read strobe, and 16-bit write data; 8-bit registers take the low byte. A sticky lock bit in control word 1 freezes the SMI-route enable until reset. The message, data-count and IRQ-generate registers are plain storage.

Top module: `twostage_wdog`

## Requirements
- R1: After reset the registers read as follows, and the countdown is stopped so ticks produce no pulses:
  - timer value (0x12) reads 0x0004;
  - control 2 (0x0A) reads 0x0008;
  - IRQ-generate (0x10) reads 0x0003;
  - every other register reads 0.
- R2: The register offsets are:
  - 0x00 reload/count; 0x02 data-in; 0x03 data-out;
  - 0x04 status 1; 0x06 status 2;
  - 0x08 control 1; 0x0A control 2;
  - 0x0C message A; 0x0D message B; 0x0E data count;
  - 0x10 IRQ-generate; 0x12 timer value.

  8-bit registers read zero-extended. Any other offset reads 0, and writes to it change nothing.
- R3: Written values are masked before they are stored: control 1 with 0xFEFF, status 1 with 0xE870, status 2 with 0xFFF8.
- R4: The countdown may run only while control 1 bit 11 (halt) is 0 and the timer value is greater than 1. A write to control 1 checks this condition. If it holds, the count reloads from the timer value and runs; if not, the countdown stops.
- R5: A write to 0x00 clears the consecutive-expiry count. If the countdown may run (R4), the count is reloaded from the timer value and runs. Otherwise the written word is stored and reads back at 0x00.
- R6: While the countdown runs, 0x00 reads the remaining ticks in bits 9:0 and the stored upper bits in 15:10. Each tick lowers the remaining count by one. Expiry happens on the tick that finds 1 or less remaining, so a load of N expires on the N-th tick.
- R7: Every expiry sets status 1 bit 3. An expiry that does not reset pulses `smi_pulse` when the SMI route is enabled, or `nmi_pulse` otherwise, and reloads the count from the timer value.
- R8: A second expiry with no reload in between sets status 2 bits 1 and 2 and clears the expiry count. If `no_reboot` is low, it pulses `rst_req` with no interrupt, stops the countdown and clears 0x00. If `no_reboot` is high, it behaves as R7.
- R9: Control 1 bit 12 (lock) cannot be cleared by a write, only by reset. While it is set, the internal SMI route enable holds its value and ignores `route_smi`.
- R10: Writing data-in stores the byte, sets status 1 bit 1 and pulses `smi_pulse`. Writing data-out stores the byte and sets status 1 bit 2, with no pulse.
- R11: `smi_pulse`, `nmi_pulse` and `rst_req` each go high for exactly one cycle per event.
- R12: When a write to 0x00 or control 1 lands in the same cycle as an expiring tick, the write wins: no expiry happens and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle countdown tick from the prescaler |
| route_smi | input | 1 | Requested SMI route enable (frozen while locked) |
| no_reboot | input | 1 | Strap that inhibits the reset request |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe |
| addr | input | 5 | Byte offset in the register window |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the strobe cycle |
| smi_pulse | output | 1 | System-management interrupt pulse |
| nmi_pulse | output | 1 | Non-maskable interrupt pulse |
| rst_req | output | 1 | System reset request pulse |

## Verification
A remaining count that is off by one shows up one tick early or late: the pulse moves, and a readback of 0x00 during the countdown is wrong in the same cycle. A consecutive-expiry count that was not cleared by a reload turns a harmless interrupt into `rst_req` on the very next expiry. A route bit that leaks through the lock swaps `smi_pulse` for `nmi_pulse` on the next expiry. A halted or too-small timer that still runs produces a pulse after just a few ticks, where none should come.

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int AW    = 5,
  parameter int DW    = 16,
  parameter int CNT_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          route_smi,
  input  logic          no_reboot,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          smi_pulse,
  output logic          nmi_pulse,
  output logic          rst_req
);
  localparam int HI_W = DW - CNT_W;

  logic [DW-1:0]    rld_q, sts1_q, sts2_q, ctl1_q, ctl2_q, tmr_q;
  logic [7:0]       din_q, dout_q, msga_q, msgb_q, dcnt_q, irqg_q;
  logic [CNT_W-1:0] remain_q;
  logic             running_q, once_q, route_q;
  logic             smi_q, nmi_q, rst_q;

  wire hit_rld  = wr && addr == AW'(8'h00);
  wire hit_ctl1 = wr && addr == AW'(8'h08);
  wire may_run  = !ctl1_q[11] && tmr_q > DW'(1);
  wire [DW-1:0] ctl1_new = (wdata & DW'(16'hFEFF)) | (ctl1_q & DW'(16'h1000));
  wire may_run_new = !ctl1_new[11] && tmr_q > DW'(1);
  wire step     = running_q && tick_en && !hit_rld && !hit_ctl1;
  wire expire   = step && remain_q <= CNT_W'(1);
  wire go_reset = expire && once_q && !no_reboot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q <= '0; sts1_q <= '0; sts2_q <= '0; ctl1_q <= '0;
      ctl2_q <= DW'(16'h0008); tmr_q <= DW'(16'h0004);
      din_q <= '0; dout_q <= '0; msga_q <= '0; msgb_q <= '0;
      dcnt_q <= '0; irqg_q <= 8'h03;
      remain_q <= '0; running_q <= 1'b0; once_q <= 1'b0; route_q <= 1'b0;
      smi_q <= 1'b0; nmi_q <= 1'b0; rst_q <= 1'b0;
    end else begin
      smi_q <= 1'b0;
      nmi_q <= 1'b0;
      rst_q <= 1'b0;
      if (!ctl1_q[12]) route_q <= route_smi;
      if (step && !expire) remain_q <= remain_q - CNT_W'(1);
      if (expire) begin
        sts1_q[3] <= 1'b1;
        if (once_q) begin
          sts2_q[1] <= 1'b1;
          sts2_q[2] <= 1'b1;
          once_q    <= 1'b0;
        end else begin
          once_q <= 1'b1;
        end
        if (go_reset) begin
          rst_q     <= 1'b1;
          running_q <= 1'b0;
          rld_q     <= '0;
        end else begin
          if (route_q) smi_q <= 1'b1;
          else         nmi_q <= 1'b1;
          rld_q    <= tmr_q;
          remain_q <= tmr_q[CNT_W-1:0];
        end
      end
      if (wr) begin
        case (addr)
          AW'(8'h00): begin
            once_q <= 1'b0;
            if (may_run) begin
              rld_q <= tmr_q; remain_q <= tmr_q[CNT_W-1:0]; running_q <= 1'b1;
            end else begin
              rld_q <= wdata;
            end
          end
          AW'(8'h02): begin din_q <= wdata[7:0]; sts1_q[1] <= 1'b1; smi_q <= 1'b1; end
          AW'(8'h03): begin dout_q <= wdata[7:0]; sts1_q[2] <= 1'b1; end
          AW'(8'h04): sts1_q <= wdata & DW'(16'hE870);
          AW'(8'h06): sts2_q <= wdata & DW'(16'hFFF8);
          AW'(8'h08): begin
            ctl1_q <= ctl1_new;
            if (may_run_new) begin
              rld_q <= tmr_q; remain_q <= tmr_q[CNT_W-1:0]; running_q <= 1'b1;
            end else begin
              running_q <= 1'b0;
            end
          end
          AW'(8'h0A): ctl2_q <= wdata;
          AW'(8'h0C): msga_q <= wdata[7:0];
          AW'(8'h0D): msgb_q <= wdata[7:0];
          AW'(8'h0E): dcnt_q <= wdata[7:0];
          AW'(8'h10): irqg_q <= wdata[7:0];
          AW'(8'h12): tmr_q  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        AW'(8'h00): rdata = running_q ? {rld_q[DW-1:CNT_W], remain_q} : rld_q;
        AW'(8'h02): rdata = DW'(din_q);
        AW'(8'h03): rdata = DW'(dout_q);
        AW'(8'h04): rdata = sts1_q;
        AW'(8'h06): rdata = sts2_q;
        AW'(8'h08): rdata = ctl1_q;
        AW'(8'h0A): rdata = ctl2_q;
        AW'(8'h0C): rdata = DW'(msga_q);
        AW'(8'h0D): rdata = DW'(msgb_q);
        AW'(8'h0E): rdata = DW'(dcnt_q);
        AW'(8'h10): rdata = DW'(irqg_q);
        AW'(8'h12): rdata = tmr_q;
        default:    rdata = '0;
      endcase
    end
  end

  assign smi_pulse = smi_q;
  assign nmi_pulse = nmi_q;
  assign rst_req   = rst_q;

  a_r4_halt_stops: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> !ctl1_q[11]);
  a_r7_nmi_only_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> !$past(route_q));
  a_r8_reset_stops: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> (!running_q && !nmi_q));
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1_q[12] |=> ctl1_q[12]);
  a_r9_route_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ctl1_q[12] |=> $stable(route_q));
  a_r11_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  initial begin
    if (HI_W < 0) $error("counter wider than data");
  end
endmodule

// File: tb/tb_twostage_wdog.sv
module tb_twostage_wdog;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, route_smi = 1'b0, no_reboot = 1'b1;
  logic wr = 1'b0, rd = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic smi_pulse, nmi_pulse, rst_req;
  int total = 0, bad = 0;
  bit done = 0;
  logic p_smi, p_nmi, p_rst;
  logic [15:0] rv;

  always #2 clk = ~clk;

  twostage_wdog dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .route_smi(route_smi), .no_reboot(no_reboot), .wr(wr), .rd(rd),
    .addr(addr), .wdata(wdata), .rdata(rdata), .smi_pulse(smi_pulse),
    .nmi_pulse(nmi_pulse), .rst_req(rst_req));

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  task automatic grab();
    p_smi = smi_pulse; p_nmi = nmi_pulse; p_rst = rst_req;
  endtask

  task automatic wreg(logic [4:0] a, logic [15:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; grab();
  endtask

  task automatic rreg(logic [4:0] a, output logic [15:0] v);
    @(negedge clk); rd = 1'b1; addr = a; #1 v = rdata; rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0; grab();
  endtask

  task automatic kick_on_tick();
    @(negedge clk); tick_en = 1'b1; wr = 1'b1; addr = 5'h00; wdata = 16'h0;
    @(negedge clk); tick_en = 1'b0; wr = 1'b0; grab();
  endtask

  task automatic quiet_ticks(int n, string req);
    int any = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      any |= int'(p_smi) | int'(p_nmi) | int'(p_rst);
    end
    chk(req, any, 0);
  endtask

  task automatic expect_pulse(string req, int s, int n, int r);
    chk(req, {29'd0, p_smi, p_nmi, p_rst}, (s << 2) | (n << 1) | r);
  endtask

  function automatic logic [15:0] reset_val(logic [4:0] a);
    case (a)
      5'h12: return 16'h0004;
      5'h0A: return 16'h0008;
      5'h10: return 16'h0003;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] stored_val(logic [4:0] a, logic [15:0] d);
    return (a == 5'h0A) ? d : {8'h00, d[7:0]};
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: run hung got=1 exp=0");
    report();
  end

  initial begin
    logic [4:0] rst_list [12];
    logic [4:0] sto [5];
    rst_list = '{5'h00,5'h02,5'h03,5'h04,5'h06,5'h08,5'h0A,5'h0C,5'h0D,5'h0E,5'h10,5'h12};
    sto = '{5'h0A,5'h0C,5'h0D,5'h0E,5'h10};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values and stopped timer
    foreach (rst_list[i]) begin
      rreg(rst_list[i], rv); chk("R1 reset value", rv, reset_val(rst_list[i]));
    end
    quiet_ticks(8, "R1 stopped after reset");
    // R2 unmapped offsets and byte registers
    wreg(5'h14, 16'hFFFF); rreg(5'h14, rv); chk("R2 unmapped read", rv, 0);
    rreg(5'h01, rv); chk("R2 odd offset read", rv, 0);
    rreg(5'h12, rv); chk("R2 unmapped write no effect", rv, 16'h0004);
    wreg(5'h0C, 16'hABCD); rreg(5'h0C, rv); chk("R2 byte reg", rv, 16'h00CD);
    // random storage traffic
    for (int k = 0; k < 300; k++) begin
      logic [4:0] a;
      logic [15:0] d;
      a = sto[$urandom_range(0, 4)];
      d = 16'($urandom);
      wreg(a, d); rreg(a, rv); chk("R2 storage readback", rv, stored_val(a, d));
    end
    // R3 masks
    wreg(5'h08, 16'hEFFF); rreg(5'h08, rv); chk("R3 control1 mask", rv, 16'hEEFF);
    wreg(5'h04, 16'hFFFF); rreg(5'h04, rv); chk("R3 status1 mask", rv, 16'hE870);
    wreg(5'h06, 16'hFFFF); rreg(5'h06, rv); chk("R3 status2 mask", rv, 16'hFFF8);
    wreg(5'h04, 16'h0); wreg(5'h06, 16'h0);
    // R5 halted: reload write is stored
    wreg(5'h08, 16'h0800);
    wreg(5'h00, 16'h1234); rreg(5'h00, rv); chk("R5 store when halted", rv, 16'h1234);
    quiet_ticks(6, "R4 halted no expiry");
    // R4/R6/R7 countdown and first expiry
    wreg(5'h12, 16'h0405);
    wreg(5'h08, 16'h0000);
    rreg(5'h00, rv); chk("R6 start readback", rv, 16'h0405);
    quiet_ticks(4, "R6 no early expiry");
    rreg(5'h00, rv); chk("R6 remaining count", rv, 16'h0401);
    tick(); expect_pulse("R7 first expiry nmi", 0, 1, 0);
    @(negedge clk); chk("R11 nmi single cycle", nmi_pulse, 0);
    rreg(5'h04, rv); chk("R7 timeout status", rv, 16'h0008);
    rreg(5'h00, rv); chk("R7 reloaded", rv, 16'h0405);
    // R8 second expiry with reboot inhibited
    quiet_ticks(4, "R8 countdown");
    tick(); expect_pulse("R8 inhibited second expiry", 0, 1, 0);
    rreg(5'h06, rv); chk("R8 second status", rv, 16'h0006);
    route_smi = 1'b1;
    quiet_ticks(4, "R7 countdown");
    tick(); expect_pulse("R7 routed smi", 1, 0, 0);
    // R8 second expiry resets
    wreg(5'h06, 16'h0); no_reboot = 1'b0;
    quiet_ticks(4, "R8 countdown");
    tick(); expect_pulse("R8 reset request", 0, 0, 1);
    @(negedge clk); chk("R11 reset single cycle", rst_req, 0);
    rreg(5'h06, rv); chk("R8 status after reset", rv, 16'h0006);
    rreg(5'h00, rv); chk("R8 count cleared", rv, 16'h0000);
    quiet_ticks(7, "R8 stopped after reset");
    // R5 kick clears consecutive count
    wreg(5'h06, 16'h0);
    wreg(5'h08, 16'h0000);
    quiet_ticks(4, "R5 countdown");
    tick(); expect_pulse("R5 first expiry", 1, 0, 0);
    wreg(5'h00, 16'h0);
    quiet_ticks(4, "R5 countdown");
    tick(); expect_pulse("R5 kick prevents reset", 1, 0, 0);
    rreg(5'h06, rv); chk("R5 no second status", rv, 16'h0000);
    // R12 kick on the expiring tick wins
    quiet_ticks(4, "R12 countdown");
    kick_on_tick(); expect_pulse("R12 kick wins", 0, 0, 0);
    rreg(5'h00, rv); chk("R12 reloaded", rv, 16'h0405);
    quiet_ticks(4, "R12 countdown");
    tick(); expect_pulse("R12 cleared count", 1, 0, 0);
    // R4 halt while running, and timer value 1
    wreg(5'h08, 16'h0800);
    quiet_ticks(6, "R4 halt stops");
    wreg(5'h12, 16'h0001); wreg(5'h08, 16'h0000);
    quiet_ticks(6, "R4 value 1 ignored");
    wreg(5'h00, 16'h00AB); rreg(5'h00, rv); chk("R4 value 1 store", rv, 16'h00AB);
    // R10 data-in and data-out
    wreg(5'h04, 16'h0);
    wreg(5'h02, 16'h015A); expect_pulse("R10 data-in smi", 1, 0, 0);
    @(negedge clk); chk("R11 smi single cycle", smi_pulse, 0);
    rreg(5'h04, rv); chk("R10 sw smi status", rv, 16'h0002);
    rreg(5'h02, rv); chk("R10 data-in stored", rv, 16'h005A);
    wreg(5'h03, 16'h02C3); expect_pulse("R10 data-out no pulse", 0, 0, 0);
    rreg(5'h04, rv); chk("R10 data-out status", rv, 16'h0006);
    rreg(5'h03, rv); chk("R10 data-out stored", rv, 16'h00C3);
    // R9 lock
    no_reboot = 1'b1;
    wreg(5'h12, 16'h0003);
    wreg(5'h08, 16'h1000);
    route_smi = 1'b0;
    repeat (3) @(negedge clk);
    wreg(5'h08, 16'h0000); rreg(5'h08, rv); chk("R9 lock sticky", rv, 16'h1000);
    quiet_ticks(2, "R9 countdown");
    tick(); expect_pulse("R9 route frozen smi", 1, 0, 0);
    report();
  end
endmodule